// File: doc/BRIEF.md
# Multimode Timer Core

A 16-bit up/down counter that advances on the expiry of an 8-bit prescaler and is steered by a small set of mode inputs. In reload operation the counter runs to its terminal value and is reloaded from a data register, giving a programmable period. With the first data register set up for capture, the counter runs freely across its full range, and rising edges on a capture input latch the running count. A compare register can trigger a match pulse and, optionally, restart the count. Capture can restart the count too, which leaves the interval between two edges in the first data register.

A bivalue option pairs the two data registers. In reload operation they take turns as the reload source, giving two alternating periods. In capture operation they take turns as the capture destination. While neither bivalue nor hold is selected, the second data register shadows the live count, so the count can be read without disturbing it. The block is one core of a larger timer. Register decoding, pin waveform logic and interrupt routing sit around it.

Top module: `multimode_timer`

## Requirements
- R1: While `rst_n` is low the count, both data registers and the compare register are 0000h, and `end_pulse`, `match_pulse` and `cap_pulse` are low.
- R2: The counter takes one step on each prescaler expiry, which happens once every `psc_div`+1 clocks. After any clear, the first step comes `psc_div`+1 clocks after the clearing edge.
- R3: A clear loads 0000h when `count_down`=0 and FFFFh when `count_down`=1. A clear outranks a step or reload in the same cycle, and it raises no end-of-count pulse.
- R4: With `r0_capture`=0 and `bivalue_en`=0, a step taken at FFFFh (up) or 0000h (down) loads the counter from R0 instead. `end_pulse` is high for exactly the cycle that shows the reloaded value.
- R5: With `r0_capture`=1 the counter is free running. It wraps FFFFh to 0000h upward and 0000h to FFFFh downward, with no reload and no end-of-count pulse.
- R6: With `r0_capture`=1, a rising edge on `cap_in` stores the count held in that clock cycle into R0 and gives a one-cycle `cap_pulse`. With `r0_capture`=0, edges change neither R0 nor `cap_pulse`.
- R7: With `clr_on_cap`=1, each capture into R0 also clears the counter and restarts the prescaler.
- R8: A step taken while the count equals C0 gives a one-cycle `match_pulse`. With `clr_on_cmp`=1, that step becomes a clear, so the count cycles through C0+1 values.
- R9: With `bivalue_en`=0 and `r1_hold`=0, R1 equals the count in every cycle and R1 writes are overridden. With `r1_hold`=1, R1 keeps the value last written through `r1_wr`.
- R10: With `bivalue_en`=1 and `r0_capture`=0, successive end-of-count reloads come from R0, R1, R0, and so on. The first reload after `bivalue_en` rises is always from R0.
- R11: With `bivalue_en`=1 and `r0_capture`=1, successive captures go to R0, R1, R0, and so on, starting with R0 after `bivalue_en` rises. Only captures into R0 clear the counter under `clr_on_cap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bivalue_en | input | 1 | Pair R0 and R1 for alternating reload or capture |
| r0_capture | input | 1 | 1: R0 is a capture register and the counter runs free; 0: R0 is a reload register |
| r1_hold | input | 1 | 1: R1 holds written data; 0 (with bivalue off): R1 follows the count |
| count_down | input | 1 | Count direction, 1 for down |
| clr_on_cap | input | 1 | Clear the counter on capture into R0 |
| clr_on_cmp | input | 1 | Clear the counter on compare match |
| psc_div | input | 8 | Prescaler divide value; the step rate is clk/(psc_div+1) |
| clear_req | input | 1 | One-cycle clear command |
| r0_wr | input | 1 | Write `wr_data` into R0 |
| r1_wr | input | 1 | Write `wr_data` into R1 |
| c0_wr | input | 1 | Write `wr_data` into C0 |
| wr_data | input | 16 | Write data |
| cap_in | input | 1 | Capture input, active on its rising edge |
| count | output | 16 | Counter value |
| r0_val | output | 16 | R0 contents |
| r1_val | output | 16 | R1 contents |
| end_pulse | output | 1 | End-of-count reload pulse |
| match_pulse | output | 1 | Compare-match pulse |
| cap_pulse | output | 1 | Capture event pulse |

## Verification
A clear command and an end-of-count reload can land on the same clock edge. The bench provokes this by raising the clear command in the very cycle in which the upward count sits at FFFFh and a prescaler step is due. It then checks that the counter shows 0000h rather than the R0 value, and that no end-of-count pulse appears. A capture that clears the counter on the same edge as a prescaler step is also covered. The captured value must be the count before that step, and the following step must wait a full prescale period.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

   // Which of the two data registers is the current reload source or capture target
   typedef enum logic {
      SEL_R0 = 1'b0,
      SEL_R1 = 1'b1
   } alt_sel_e;

endpackage

// File: rtl/mmt_prescaler.sv
module mmt_prescaler #(
   parameter int PSC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PSC_W-1:0] div,
   input  logic             restart,
   output logic             tick
);

   logic [PSC_W-1:0] psc_q;

   assign tick = (psc_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_q <= '0;
      end else if (restart || tick) begin
         psc_q <= div;
      end else begin
         psc_q <= psc_q - 1'b1;
      end
   end

endmodule

// File: rtl/mmt_counter.sv
module mmt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clear,
   input  logic             dir_down,
   input  logic             free_run,
   input  logic [CNT_W-1:0] reload_val,
   input  logic [CNT_W-1:0] cmp_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_d,
   output logic             match_evt,
   output logic             reload_evt,
   output logic             end_pulse_q,
   output logic             match_pulse_q
);

   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   logic [CNT_W-1:0] end_val;
   logic [CNT_W-1:0] clr_val;

   assign end_val    = dir_down ? '0 : ALL_ONES;
   assign clr_val    = dir_down ? ALL_ONES : '0;
   assign match_evt  = tick && (cnt_q == cmp_val);
   assign reload_evt = tick && !clear && !free_run && (cnt_q == end_val);

   always_comb begin
      if (clear) begin
         cnt_d = clr_val;
      end else if (reload_evt) begin
         cnt_d = reload_val;
      end else if (tick) begin
         cnt_d = dir_down ? cnt_q - 1'b1 : cnt_q + 1'b1;
      end else begin
         cnt_d = cnt_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q         <= '0;
         end_pulse_q   <= 1'b0;
         match_pulse_q <= 1'b0;
      end else begin
         cnt_q         <= cnt_d;
         end_pulse_q   <= reload_evt;
         match_pulse_q <= match_evt;
      end
   end

endmodule

// File: rtl/mmt_datareg.sv
module mmt_datareg
   import mmt_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int N_DATA = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_in,
   input  logic             capture_mode,
   input  logic             bivalue,
   input  logic             monitor,
   input  logic             reload_evt,
   input  logic             wr_r0,
   input  logic             wr_r1,
   input  logic             wr_c0,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [CNT_W-1:0] cnt_q,
   input  logic [CNT_W-1:0] cnt_d,
   output logic [CNT_W-1:0] r0_q,
   output logic [CNT_W-1:0] r1_q,
   output logic [CNT_W-1:0] c0_q,
   output logic [CNT_W-1:0] reload_val,
   output logic             cap_into_r0,
   output logic             cap_pulse_q
);

   alt_sel_e          sel_q;
   logic              cap_prev_q;
   logic              cap_take;
   logic [N_DATA-1:0] cap_dst;
   logic [N_DATA-1:0] wr_vec;
   logic [N_DATA-1:0] mon_vec;
   logic [CNT_W-1:0]  dval [N_DATA];

   assign cap_take   = capture_mode && cap_in && !cap_prev_q;
   assign cap_dst[0] = cap_take && (!bivalue || sel_q == SEL_R0);
   assign cap_dst[1] = cap_take && bivalue && (sel_q == SEL_R1);
   assign wr_vec     = {wr_r1, wr_r0};
   assign mon_vec    = {monitor, 1'b0};

   // One storage slot per data register; only the second one can shadow the count
   for (genvar gi = 0; gi < N_DATA; gi++) begin : g_data
      logic [CNT_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (cap_dst[gi]) begin
            q <= cnt_q;
         end else if (mon_vec[gi]) begin
            q <= cnt_d;
         end else if (wr_vec[gi]) begin
            q <= wr_data;
         end
      end
      assign dval[gi] = q;
   end

   assign r0_q        = dval[0];
   assign r1_q        = dval[1];
   assign reload_val  = (sel_q == SEL_R1) ? dval[1] : dval[0];
   assign cap_into_r0 = cap_dst[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q       <= SEL_R0;
         cap_prev_q  <= 1'b0;
         cap_pulse_q <= 1'b0;
         c0_q        <= '0;
      end else begin
         cap_prev_q  <= cap_in;
         cap_pulse_q <= cap_take;
         if (wr_c0) begin
            c0_q <= wr_data;
         end
         if (!bivalue) begin
            sel_q <= SEL_R0;
         end else if (cap_take || reload_evt) begin
            sel_q <= (sel_q == SEL_R0) ? SEL_R1 : SEL_R0;
         end
      end
   end

endmodule

// File: rtl/multimode_timer.sv
module multimode_timer #(
   parameter int CNT_W = 16,
   parameter int PSC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bivalue_en,
   input  logic             r0_capture,
   input  logic             r1_hold,
   input  logic             count_down,
   input  logic             clr_on_cap,
   input  logic             clr_on_cmp,
   input  logic [PSC_W-1:0] psc_div,
   input  logic             clear_req,
   input  logic             r0_wr,
   input  logic             r1_wr,
   input  logic             c0_wr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             cap_in,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] r0_val,
   output logic [CNT_W-1:0] r1_val,
   output logic             end_pulse,
   output logic             match_pulse,
   output logic             cap_pulse
);

   localparam int N_DATA = 2;

   if (CNT_W < 4) begin : g_bad_cnt_w
      $error("multimode_timer: CNT_W must be at least 4");
   end
   if (PSC_W < 1 || PSC_W > CNT_W) begin : g_bad_psc_w
      $error("multimode_timer: PSC_W must lie in 1..CNT_W");
   end

   logic             tick;
   logic             clear_all;
   logic             monitor;
   logic             match_evt;
   logic             reload_evt;
   logic             cap_into_r0;
   logic [CNT_W-1:0] cnt_d;
   logic [CNT_W-1:0] c0_q;
   logic [CNT_W-1:0] reload_val;

   assign monitor   = !bivalue_en && !r1_hold;
   assign clear_all = clear_req
                    || (clr_on_cmp && match_evt)
                    || (clr_on_cap && cap_into_r0);

   mmt_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .div     (psc_div),
      .restart (clear_all),
      .tick    (tick)
   );

   mmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick          (tick),
      .clear         (clear_all),
      .dir_down      (count_down),
      .free_run      (r0_capture),
      .reload_val    (reload_val),
      .cmp_val       (c0_q),
      .cnt_q         (count),
      .cnt_d         (cnt_d),
      .match_evt     (match_evt),
      .reload_evt    (reload_evt),
      .end_pulse_q   (end_pulse),
      .match_pulse_q (match_pulse)
   );

   mmt_datareg #(.CNT_W(CNT_W), .N_DATA(N_DATA)) u_dreg (
      .clk          (clk),
      .rst_n        (rst_n),
      .cap_in       (cap_in),
      .capture_mode (r0_capture),
      .bivalue      (bivalue_en),
      .monitor      (monitor),
      .reload_evt   (reload_evt),
      .wr_r0        (r0_wr),
      .wr_r1        (r1_wr),
      .wr_c0        (c0_wr),
      .wr_data      (wr_data),
      .cnt_q        (count),
      .cnt_d        (cnt_d),
      .r0_q         (r0_val),
      .r1_q         (r1_val),
      .c0_q         (c0_q),
      .reload_val   (reload_val),
      .cap_into_r0  (cap_into_r0),
      .cap_pulse_q  (cap_pulse)
   );

endmodule

// File: rtl/mmt_checker.sv
module mmt_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bivalue_en,
   input logic             r0_capture,
   input logic             r1_hold,
   input logic             count_down,
   input logic             clear_req,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] r1_val,
   input logic             end_pulse,
   input logic             cap_pulse
);

   a_r3_clear_up: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_req && !count_down) |=> (count == '0));

   a_r3_clear_down: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_req && count_down) |=> (count == {CNT_W{1'b1}}));

   a_r3_clear_no_end: assert property (@(posedge clk) disable iff (!rst_n)
      clear_req |=> !end_pulse);

   a_r5_free_no_end: assert property (@(posedge clk) disable iff (!rst_n)
      r0_capture |=> !end_pulse);

   a_r6_ignored_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !r0_capture |=> !cap_pulse);

   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cap_pulse |=> !cap_pulse);

   a_r9_monitor_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      (!bivalue_en && !r1_hold) |=> (r1_val == count));

endmodule

bind multimode_timer mmt_checker #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bivalue_en (bivalue_en),
   .r0_capture (r0_capture),
   .r1_hold    (r1_hold),
   .count_down (count_down),
   .clear_req  (clear_req),
   .count      (count),
   .r1_val     (r1_val),
   .end_pulse  (end_pulse),
   .cap_pulse  (cap_pulse)
);

// File: tb/sim_multimode_timer.sv
module sim_multimode_timer;

   localparam int F_CNT = 0, F_R0 = 1, F_R1 = 2, F_END = 3, F_MATCH = 4, F_CAP = 5;

   typedef struct {
      int          fld;
      logic [15:0] exp;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bivalue_en = 0, r0_capture = 0, r1_hold = 0, count_down = 0;
   logic        clr_on_cap = 0, clr_on_cmp = 0, clear_req = 0;
   logic        r0_wr = 0, r1_wr = 0, c0_wr = 0, cap_in = 0;
   logic [7:0]  psc_div = 8'd0;
   logic [15:0] wr_data = 16'h0;
   logic [15:0] count, r0_val, r1_val;
   logic        end_pulse, match_pulse, cap_pulse;

   int    n_checks = 0;
   int    n_fail = 0;
   bit    done = 0;
   item_t sb[$];

   always #2 clk = ~clk;

   multimode_timer u0 (
      .clk(clk), .rst_n(rst_n), .bivalue_en(bivalue_en), .r0_capture(r0_capture),
      .r1_hold(r1_hold), .count_down(count_down), .clr_on_cap(clr_on_cap),
      .clr_on_cmp(clr_on_cmp), .psc_div(psc_div), .clear_req(clear_req),
      .r0_wr(r0_wr), .r1_wr(r1_wr), .c0_wr(c0_wr), .wr_data(wr_data),
      .cap_in(cap_in), .count(count), .r0_val(r0_val), .r1_val(r1_val),
      .end_pulse(end_pulse), .match_pulse(match_pulse), .cap_pulse(cap_pulse)
   );

   function automatic logic [15:0] actual(int fld);
      case (fld)
         F_CNT:   return count;
         F_R0:    return r0_val;
         F_R1:    return r1_val;
         F_END:   return {15'd0, end_pulse};
         F_MATCH: return {15'd0, match_pulse};
         default: return {15'd0, cap_pulse};
      endcase
   endfunction

   // Monitor: compares queued expectations just after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sb.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it  = sb.pop_front();
            act = actual(it.fld);
            n_checks++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s field %0d: actual %h expected %h", it.tag, it.fld, act, it.exp);
            end
         end
      end
   end

   task automatic expect_val(int fld, logic [15:0] v, string tag);
      item_t it;
      it.fld = fld; it.exp = v; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(bit check);
      @(negedge clk);
      rst_n = 0;
      bivalue_en = 0; r0_capture = 0; r1_hold = 0; count_down = 0;
      clr_on_cap = 0; clr_on_cmp = 0; clear_req = 0; psc_div = 0;
      r0_wr = 0; r1_wr = 0; c0_wr = 0; cap_in = 0; wr_data = 0;
      wait_n(2);
      if (check) begin
         expect_val(F_CNT, 16'h0, "R1"); expect_val(F_R0, 16'h0, "R1");
         expect_val(F_R1, 16'h0, "R1");  expect_val(F_END, 16'h0, "R1");
         expect_val(F_MATCH, 16'h0, "R1"); expect_val(F_CAP, 16'h0, "R1");
      end
      wait_n(1);
      rst_n = 1;
   endtask

   task automatic clr_pulse(bit down);
      count_down = down;
      clear_req  = 1;
      wait_n(1);
      clear_req  = 0;
   endtask

   initial begin
      do_reset(1);

      // R2: prescaler divide by 3, restarted by a clear
      psc_div = 8'd2;
      clr_pulse(0);
      expect_val(F_CNT, 16'h0000, "R3");
      wait_n(2); expect_val(F_CNT, 16'h0000, "R2");
      wait_n(1); expect_val(F_CNT, 16'h0001, "R2");
      wait_n(3); expect_val(F_CNT, 16'h0002, "R2");

      // R4 upward reload, R9 monitor, R3 clear against end of count
      do_reset(0);
      r0_wr = 1; wr_data = 16'hFFFC;
      clr_pulse(1);
      r0_wr = 0; count_down = 0;
      expect_val(F_CNT, 16'hFFFF, "R3"); expect_val(F_R0, 16'hFFFC, "R4");
      wait_n(1); expect_val(F_CNT, 16'hFFFC, "R4"); expect_val(F_END, 16'h1, "R4");
      expect_val(F_R1, 16'hFFFC, "R9");
      wait_n(1); expect_val(F_CNT, 16'hFFFD, "R4"); expect_val(F_END, 16'h0, "R4");
      wait_n(2); expect_val(F_CNT, 16'hFFFF, "R4");
      wait_n(1); expect_val(F_CNT, 16'hFFFC, "R4"); expect_val(F_END, 16'h1, "R4");
      wait_n(3); expect_val(F_CNT, 16'hFFFF, "R4");
      clear_req = 1;
      wait_n(1); clear_req = 0;
      expect_val(F_CNT, 16'h0000, "R3"); expect_val(F_END, 16'h0, "R3");

      // R4 downward reload at 0000h
      do_reset(0);
      r0_wr = 1; wr_data = 16'h0002;
      clr_pulse(0);
      r0_wr = 0; count_down = 1;
      wait_n(1); expect_val(F_CNT, 16'h0002, "R4"); expect_val(F_END, 16'h1, "R4");
      wait_n(2); expect_val(F_CNT, 16'h0000, "R4"); expect_val(F_END, 16'h0, "R4");
      wait_n(1); expect_val(F_CNT, 16'h0002, "R4"); expect_val(F_END, 16'h1, "R4");

      // R5 free running wrap both ways
      do_reset(0);
      r0_capture = 1;
      clr_pulse(1);
      count_down = 0;
      wait_n(1); expect_val(F_CNT, 16'h0000, "R5"); expect_val(F_END, 16'h0, "R5");
      count_down = 1;
      wait_n(1); expect_val(F_CNT, 16'hFFFF, "R5"); expect_val(F_END, 16'h0, "R5");

      // R6 capture and ignored edge
      do_reset(0);
      r0_capture = 1;
      clr_pulse(0);
      wait_n(4); expect_val(F_CNT, 16'h0004, "R6");
      cap_in = 1;
      wait_n(1); expect_val(F_R0, 16'h0004, "R6"); expect_val(F_CAP, 16'h1, "R6");
      expect_val(F_CNT, 16'h0005, "R6");
      wait_n(1); expect_val(F_CAP, 16'h0, "R6");
      cap_in = 0; r0_capture = 0;
      wait_n(2);
      cap_in = 1;
      wait_n(1); expect_val(F_CAP, 16'h0, "R6"); expect_val(F_R0, 16'h0004, "R6");
      cap_in = 0;

      // R7 clear on capture restarts the prescaler (divide by 4)
      do_reset(0);
      r0_capture = 1; clr_on_cap = 1; psc_div = 8'd3;
      clr_pulse(0);
      wait_n(9); expect_val(F_CNT, 16'h0002, "R7");
      cap_in = 1;
      wait_n(1); expect_val(F_R0, 16'h0002, "R7"); expect_val(F_CNT, 16'h0000, "R7");
      expect_val(F_CAP, 16'h1, "R7");
      cap_in = 0;
      wait_n(3); expect_val(F_CNT, 16'h0000, "R7");
      wait_n(1); expect_val(F_CNT, 16'h0001, "R7");

      // R8 compare with and without clear
      do_reset(0);
      r0_capture = 1; clr_on_cmp = 1; c0_wr = 1; wr_data = 16'h0003;
      clr_pulse(0);
      c0_wr = 0;
      wait_n(3); expect_val(F_CNT, 16'h0003, "R8"); expect_val(F_MATCH, 16'h0, "R8");
      wait_n(1); expect_val(F_CNT, 16'h0000, "R8"); expect_val(F_MATCH, 16'h1, "R8");
      wait_n(1); expect_val(F_CNT, 16'h0001, "R8"); expect_val(F_MATCH, 16'h0, "R8");
      clr_on_cmp = 0;
      wait_n(2); expect_val(F_CNT, 16'h0003, "R8");
      wait_n(1); expect_val(F_CNT, 16'h0004, "R8"); expect_val(F_MATCH, 16'h1, "R8");

      // R9 hold keeps the written value while counting
      do_reset(0);
      r1_hold = 1; r1_wr = 1; wr_data = 16'h1234;
      wait_n(1); r1_wr = 0;
      wait_n(3); expect_val(F_R1, 16'h1234, "R9");

      // R10 biload alternation and restart from R0
      do_reset(0);
      r1_hold = 1; r0_wr = 1; wr_data = 16'h0002;
      wait_n(1); r0_wr = 0; r1_wr = 1; wr_data = 16'h0005;
      wait_n(1); r1_wr = 0;
      clr_pulse(0);
      count_down = 1; bivalue_en = 1;
      wait_n(1); expect_val(F_CNT, 16'h0002, "R10"); expect_val(F_END, 16'h1, "R10");
      wait_n(2); expect_val(F_CNT, 16'h0000, "R10");
      wait_n(1); expect_val(F_CNT, 16'h0005, "R10"); expect_val(F_END, 16'h1, "R10");
      wait_n(5); expect_val(F_CNT, 16'h0000, "R10");
      wait_n(1); expect_val(F_CNT, 16'h0002, "R10");
      bivalue_en = 0;
      wait_n(1); expect_val(F_CNT, 16'h0001, "R10");
      bivalue_en = 1;
      wait_n(2); expect_val(F_CNT, 16'h0002, "R10"); expect_val(F_END, 16'h1, "R10");

      // R11 bicapture alternation, only R0 capture clears
      do_reset(0);
      r0_capture = 1; clr_on_cap = 1;
      clr_pulse(0);
      bivalue_en = 1;
      wait_n(3); expect_val(F_CNT, 16'h0003, "R11");
      cap_in = 1;
      wait_n(1); expect_val(F_R0, 16'h0003, "R11"); expect_val(F_CNT, 16'h0000, "R11");
      cap_in = 0;
      wait_n(1); cap_in = 1;
      wait_n(1); expect_val(F_R1, 16'h0001, "R11"); expect_val(F_CNT, 16'h0002, "R11");
      expect_val(F_R0, 16'h0003, "R11"); expect_val(F_CAP, 16'h1, "R11");
      cap_in = 0;

      wait_n(3);
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog (all requirements): actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

endmodule